// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory that lets the bus change direction on any cycle without an idle slot. Every command is captured on a rising clock edge, and its data moves two edges later whether it is a read or a write. Because reads and writes sit in the same two-stage pipeline, a read can follow a write, or a write can follow a read, on consecutive cycles with no bubble.

A command is loaded when the load strobe is low and all three chip selects are active: two of them are active-low and one is active-high. When the load strobe is high, a burst that is in progress advances. The next burst address comes from a separate generator and arrives on its own input. The direction of that advance follows the loading command, and the byte enables are sampled again on that cycle. A deselect ends any burst, but operations already in the pipeline still complete.

A clock-enable input freezes the whole block, memory included. An asynchronous output enable can force the driver off at any time. The data bus is presented as a data-in, a data-out and a drive-enable, so that the direction of the bus can be checked on every cycle.

Top module: `lz_sram`

## Requirements
- R1: A read command sampled at edge k drives the stored word on `dout` with `dout_oe` high after edge k+1, so the value is valid when sampled at edge k+2.
- R2: For a write command sampled at edge k, `din` is captured at edge k+2 into the addressed word.
- R3: The word has four 9-bit lanes, and lane i occupies bits 9i+8 down to 9i. A write changes lane i only when `lane_we_n[i]` was low with the command. Byte enables and `din` have no effect for a read command.
- R4: `dout_oe` is low during the data cycle of a write, of a deselect and of an idle advance.
- R5: While `cke_n` is high, an edge has no effect: the pipeline, the memory, `dout` and `dout_oe` all hold, and a command or data presented then is discarded.
- R6: When `load_n` is low and any chip select is inactive, no operation starts. Operations already issued still complete.
- R7: When `load_n` is high during an active burst, a new operation is issued at `burst_addr` in the direction of the command that loaded the burst, using the byte enables of that cycle. The chip selects are ignored on that cycle.
- R8: When `out_en_n` is high, `dout_oe` is low at once, without waiting for a clock edge.
- R9: A read issued on the cycle right after a write to the same address returns the newly written lanes, merged with the old contents of the unwritten lanes.
- R10: After a synchronous reset, nothing is pending, no burst is active, `dout_oe` is low and `dout` is zero.
- R11: Reads and writes may alternate on consecutive cycles, with no idle cycle and no data loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high stalls every register |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b_n | input | 1 | Active-low chip select |
| cs_c | input | 1 | Active-high chip select |
| load_n | input | 1 | Low loads a new command; high advances a burst |
| wr_n | input | 1 | Low selects write, high selects read |
| lane_we_n | input | 4 | Active-low per-lane write enables |
| addr | input | ADDR_W | Address used for a loaded command |
| burst_addr | input | ADDR_W | Address used on a burst advance |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| din | input | 36 | Write data, sampled two edges after its command |
| dout | output | 36 | Registered read data |
| dout_oe | output | 1 | Bus drive enable for `dout` |

## Verification
A corrupted pipeline stage shows up at the ports exactly two edges after the command that should have created it. It appears either as `dout_oe` asserting in a write or deselect slot, or as `dout` carrying the wrong word in a read slot. A missing forwarding path is caught only by a read that directly follows a write to the same address, and it shows as stale lanes two edges after that read. A stall that leaks through appears on the first checked cycle after the stall, as changed output data, or as a write that landed while the clock enable was off and is later read back.

// File: rtl/lzs_pkg.sv
package lzs_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_ADVANCE,
        CMD_DESEL
    } cmd_kind_e;

    // Replace the lanes of base selected by m with the matching lanes of upd.
    function automatic word_t lane_merge(word_t base, word_t upd, lane_mask_t m);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lzs_ctrl.sv
module lzs_ctrl
    import lzs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              cs_c,
    input  logic              load_n,
    input  logic              wr_n,
    input  lane_mask_t        lane_we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] burst_addr,
    output logic              s1_valid,
    output logic              s1_wr,
    output logic [ADDR_W-1:0] s1_addr,
    output logic              s2_valid,
    output logic              s2_wr,
    output logic [ADDR_W-1:0] s2_addr,
    output lane_mask_t        s2_lanes
);

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        lane_mask_t        lanes;
    } op_t;

    op_t       st1, st2, nxt;
    logic      burst_on, burst_wr;
    logic      sel;
    cmd_kind_e kind;

    always_comb begin
        sel = !cs_a_n && !cs_b_n && cs_c;
        if (!load_n) kind = sel ? CMD_LOAD : CMD_DESEL;
        else         kind = burst_on ? CMD_ADVANCE : CMD_IDLE;

        nxt = '0;
        unique case (kind)
            CMD_LOAD: begin
                nxt.valid = 1'b1;
                nxt.wr    = !wr_n;
                nxt.addr  = addr;
                nxt.lanes = ~lane_we_n;
            end
            CMD_ADVANCE: begin
                nxt.valid = 1'b1;
                nxt.wr    = burst_wr;
                nxt.addr  = burst_addr;
                nxt.lanes = ~lane_we_n;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st1      <= '0;
            st2      <= '0;
            burst_on <= 1'b0;
            burst_wr <= 1'b0;
        end else if (!cke_n) begin
            st2 <= st1;
            st1 <= nxt;
            if (kind == CMD_LOAD) begin
                burst_on <= 1'b1;
                burst_wr <= !wr_n;
            end else if (kind == CMD_DESEL) begin
                burst_on <= 1'b0;
            end
        end
    end

    assign s1_valid = st1.valid;
    assign s1_wr    = st1.wr;
    assign s1_addr  = st1.addr;
    assign s2_valid = st2.valid;
    assign s2_wr    = st2.wr;
    assign s2_addr  = st2.addr;
    assign s2_lanes = st2.lanes;

    // R1 / R11: an active edge moves the first stage into the second unchanged.
    a_r1_stage_shift: assert property (@(posedge clk) disable iff (rst)
        !cke_n |=> (st2 == $past(st1)));

    // R5: a stalled edge leaves the whole pipeline untouched.
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(st1) && $stable(st2) && $stable(burst_on)));

    // R6: a deselect starts nothing.
    a_r6_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !load_n && !sel) |=> !st1.valid);

    // R7: an advance with no burst in progress issues nothing.
    a_r7_advance_idle: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && load_n && !burst_on) |=> !st1.valid);

endmodule

// File: rtl/lzs_store.sv
module lzs_store
    import lzs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  lane_mask_t        wr_lanes,
    input  word_t             din,
    output word_t             dout_q
);

    localparam int DEPTH = 1 << ADDR_W;

    word_t      mem [DEPTH];
    word_t      rd_word, fwd_word;
    lane_mask_t hit_mask;

    always_comb begin
        rd_word  = mem[rd_addr];
        hit_mask = (wr_valid && (wr_addr == rd_addr)) ? wr_lanes : '0;
        fwd_word = lane_merge(rd_word, din, hit_mask);
    end

    always_ff @(posedge clk) begin
        if (!cke_n && wr_valid) begin
            mem[wr_addr] <= lane_merge(mem[wr_addr], din, wr_lanes);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      dout_q <= '0;
        else if (!cke_n && rd_valid)  dout_q <= fwd_word;
    end

    // R5: the read register never moves on a stalled edge.
    a_r5_dout_hold: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> $stable(dout_q));

    // R9: a full-word write landing on the edge a read samples is forwarded.
    a_r9_bypass_full: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && rd_valid && wr_valid && (wr_addr == rd_addr) && (&wr_lanes))
        |=> (dout_q == $past(din)));

endmodule

// File: rtl/lz_sram.sv
module lz_sram
    import lzs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              cs_c,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              out_en_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe
);

    logic              s1_valid, s1_wr, s2_valid, s2_wr;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    lane_mask_t        s2_lanes;
    word_t             dout_q;
    logic              rd_phase;

    lzs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cke_n      (cke_n),
        .cs_a_n     (cs_a_n),
        .cs_b_n     (cs_b_n),
        .cs_c       (cs_c),
        .load_n     (load_n),
        .wr_n       (wr_n),
        .lane_we_n  (lane_we_n),
        .addr       (addr),
        .burst_addr (burst_addr),
        .s1_valid   (s1_valid),
        .s1_wr      (s1_wr),
        .s1_addr    (s1_addr),
        .s2_valid   (s2_valid),
        .s2_wr      (s2_wr),
        .s2_addr    (s2_addr),
        .s2_lanes   (s2_lanes)
    );

    lzs_store #(.ADDR_W(ADDR_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .rd_valid (s1_valid && !s1_wr),
        .rd_addr  (s1_addr),
        .wr_valid (s2_valid && s2_wr),
        .wr_addr  (s2_addr),
        .wr_lanes (s2_lanes),
        .din      (din),
        .dout_q   (dout_q)
    );

    assign rd_phase = s2_valid && !s2_wr;
    assign dout_oe  = !out_en_n && rd_phase;
    assign dout     = dout_q;

    // R4: the bus is never driven while a write owns the data slot.
    a_r4_write_hiz: assert property (@(posedge clk) disable iff (rst)
        (s2_valid && s2_wr) |-> !dout_oe);

endmodule

// File: tb/lz_sram_tb_top.sv
module lz_sram_tb_top;

    localparam int AW = 6;

    localparam logic [35:0] D5   = 36'hA_AAAA_AAAA;
    localparam logic [35:0] D6   = 36'h3_1234_5678;
    localparam logic [35:0] D7   = 36'h5_5555_5555;
    localparam logic [35:0] JUNK = 36'hF_0F0F_0F0F;
    localparam logic [35:0] MASK = 36'h0_07FC_01FF;  // lanes 0 and 2
    localparam logic [35:0] MRG  = (D7 & MASK) | (D5 & ~MASK);

    typedef struct packed {
        logic        ld_n;
        logic        sel;
        logic        w_n;
        logic [5:0]  a;
        logic [3:0]  ln;
        logic [35:0] d;
        logic        eo;
        logic [35:0] ed;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 1'b1, 1'b0, 6'd5, 4'h0, 36'h0, 1'b0, 36'h0},   // W a5
        '{1'b0, 1'b1, 1'b0, 6'd6, 4'h0, 36'h0, 1'b0, 36'h0},   // W a6
        '{1'b0, 1'b1, 1'b1, 6'd5, 4'h0, D5,    1'b0, 36'h0},   // R a5, data for W a5
        '{1'b0, 1'b1, 1'b0, 6'd5, 4'hA, D6,    1'b0, 36'h0},   // W a5 lanes 0,2
        '{1'b0, 1'b1, 1'b1, 6'd5, 4'h0, JUNK,  1'b1, D5},      // R a5 (forward)
        '{1'b0, 1'b1, 1'b1, 6'd6, 4'h0, D7,    1'b0, 36'h0},   // R a6
        '{1'b0, 1'b0, 1'b1, 6'd0, 4'h0, JUNK,  1'b1, MRG},     // deselect
        '{1'b1, 1'b1, 1'b0, 6'd9, 4'h0, JUNK,  1'b1, D6},      // advance, no burst
        '{1'b0, 1'b0, 1'b1, 6'd0, 4'h0, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 6'd0, 4'h0, 36'h0, 1'b0, 36'h0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cke_n, cs_a_n, cs_b_n, cs_c, load_n, wr_n, out_en_n;
    logic [3:0]  lane_we_n;
    logic [AW-1:0] addr, burst_addr;
    logic [35:0] din, dout;
    logic        dout_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    lz_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .cs_c(cs_c), .load_n(load_n), .wr_n(wr_n), .lane_we_n(lane_we_n),
        .addr(addr), .burst_addr(burst_addr), .out_en_n(out_en_n),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic ld_n, input logic sel, input logic w_n,
                         input logic [AW-1:0] a, input logic [AW-1:0] ba,
                         input logic [3:0] ln, input logic [35:0] d);
        load_n     = ld_n;
        cs_a_n     = !sel;
        cs_b_n     = 1'b0;
        cs_c       = 1'b1;
        wr_n       = w_n;
        addr       = a;
        burst_addr = ba;
        lane_we_n  = ln;
        din        = d;
    endtask

    task automatic chk_bus(input logic eo, input logic [35:0] ed, input string req);
        #2;
        n_tests++;
        if (dout_oe !== eo || (eo && dout !== ed)) begin
            n_fail++;
            $display("FAIL %s: oe=%0b dout=%h expected oe=%0b dout=%h",
                     req, dout_oe, dout, eo, ed);
        end
    endtask

    initial begin
        rst = 1'b1; cke_n = 1'b0; out_en_n = 1'b0;
        drive(1'b0, 1'b0, 1'b1, '0, '0, 4'hF, '0);
        step(); step(); step();
        rst = 1'b0;

        // R10: reset state
        chk_bus(1'b0, 36'h0, "R10 oe after reset");
        n_tests++;
        if (dout !== 36'h0) begin
            n_fail++;
            $display("FAIL R10: dout=%h expected %h", dout, 36'h0);
        end

        // Table walk: R1 R2 R3 R4 R6 R9 R11
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i].ld_n, VEC[i].sel, VEC[i].w_n, VEC[i].a, VEC[i].a,
                  VEC[i].ln, VEC[i].d);
            chk_bus(VEC[i].eo, VEC[i].ed, "R1/R2/R3/R4/R6/R9/R11 table");
            step();
        end

        // R5: stall freezes state and discards inputs
        drive(1'b0, 1'b1, 1'b0, 6'd7, 6'd0, 4'h0, '0); step();
        drive(1'b0, 1'b0, 1'b1, 6'd0, 6'd0, 4'h0, '0); step();
        drive(1'b0, 1'b0, 1'b1, 6'd0, 6'd0, 4'h0, D7); step();
        drive(1'b0, 1'b1, 1'b1, 6'd6, 6'd0, 4'h0, '0); step();
        drive(1'b0, 1'b0, 1'b1, 6'd0, 6'd0, 4'h0, '0); step();
        chk_bus(1'b1, D6, "R1 read before stall");
        cke_n = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 6'd7, 6'd0, 4'h0, JUNK);
        for (int k = 0; k < 3; k++) begin
            step();
            chk_bus(1'b1, D6, "R5 hold during stall");
        end
        cke_n = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 6'd0, 6'd0, 4'h0, JUNK);
        step();
        chk_bus(1'b0, 36'h0, "R5 pipeline resumes");
        drive(1'b0, 1'b1, 1'b1, 6'd7, 6'd0, 4'h0, '0); step();
        drive(1'b0, 1'b0, 1'b1, 6'd0, 6'd0, 4'h0, '0); step();
        chk_bus(1'b1, D7, "R5 stalled write discarded");

        // R8: asynchronous output enable
        out_en_n = 1'b1;
        chk_bus(1'b0, 36'h0, "R8 oe forced off");
        out_en_n = 1'b0;
        chk_bus(1'b1, D7, "R8 oe restored");
        step(); step();

        // R7: burst write then burst read; chip selects ignored on advance
        drive(1'b0, 1'b1, 1'b0, 6'd10, 6'd0,  4'h0, '0); step();
        drive(1'b1, 1'b0, 1'b1, 6'd0,  6'd11, 4'h0, '0); step();
        drive(1'b1, 1'b0, 1'b1, 6'd0,  6'd12, 4'h0, D5); step();
        drive(1'b1, 1'b0, 1'b1, 6'd0,  6'd13, 4'h0, D6); step();
        drive(1'b0, 1'b1, 1'b1, 6'd10, 6'd0,  4'h0, D7); step();
        drive(1'b1, 1'b1, 1'b0, 6'd0,  6'd11, 4'h0, JUNK); step();
        drive(1'b1, 1'b0, 1'b0, 6'd0,  6'd12, 4'h0, '0);
        chk_bus(1'b1, D5, "R7 burst read beat 0");
        step();
        drive(1'b1, 1'b0, 1'b0, 6'd0,  6'd13, 4'h0, '0);
        chk_bus(1'b1, D6, "R7 burst read beat 1");
        step();
        drive(1'b0, 1'b0, 1'b1, 6'd0,  6'd0,  4'h0, '0);
        chk_bus(1'b1, D7, "R7 burst read beat 2");
        step();
        chk_bus(1'b1, JUNK, "R7 burst read beat 3");
        step();
        chk_bus(1'b0, 36'h0, "R6 burst ended by deselect");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule